// File: doc/BRIEF.md
# Misaligned Load Word Stitcher

This block sits between a processor load port and a memory that returns only whole 32-bit words at word-aligned addresses. A load of one, two or four bytes may start at any byte address. When every requested byte lies in one memory word, the block issues a single word read. When the bytes cross a word boundary, it issues two reads and joins the bytes from both words. The result is right-justified on the output.

A strict mode input turns alignment into a rule. In that mode, a halfword or word load whose address is not a multiple of its size is rejected with a fault and no memory read. The memory side uses a read strobe and a returned-data valid, so any read latency is accepted. While a load is in flight, a busy output tells the requester that new requests are being ignored.

Top module: `ld_word_stitch`

## Requirements
- R1: After reset, and while reset is held, busy, mem_rd_en and out_valid are 0.
- R2: A load whose bytes all fall inside one word issues exactly one read, at word address req_addr[AW-1:2].
- R3: A load whose bytes cross a word boundary issues exactly two single-cycle reads. The lower word address req_addr[AW-1:2] is read first and the next word address second.
- R4: req_size encodes the access: 00 is one byte, 01 is two bytes, 10 is four bytes. Byte order is little-endian, so result bits [8k+7:8k] hold the memory byte at address req_addr+k. Unused upper bits are zero when req_signed is 0.
- R5: When req_signed is 1, a byte or halfword result is sign-extended from its most significant loaded bit.
- R6: out_valid is a one-cycle pulse in the cycle after the cycle in which the last needed mem_rd_valid is seen.
- R7: busy is high from the cycle after a load is accepted until its result is delivered. A request presented while busy is high is ignored and causes no read and no result.
- R8: With strict_align high, a two-byte load at an odd address and a four-byte load whose address is not a multiple of 4 produce out_valid with out_fault=1 and out_data=0 in the cycle after the request, with no read and busy staying low. One-byte loads never fault.
- R9: req_size 11 is reserved and faults as in R8, in either mode.
- R10: With strict_align low, misaligned two-byte and four-byte loads complete without a fault and with out_fault=0.
- R11: A load that crosses the top of the address space reads the last word and then word address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request, taken when busy is low |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend a narrow result |
| strict_align | input | 1 | Fault on misaligned loads instead of splitting |
| busy | output | 1 | A load is in flight; requests are ignored |
| mem_rd_en | output | 1 | Word read strobe, one cycle per read |
| mem_rd_addr | output | AW-2 | Word address of the read |
| mem_rd_valid | input | 1 | Read data present on mem_rd_data |
| mem_rd_data | input | DATA_W | Returned memory word |
| out_valid | output | 1 | Result pulse |
| out_data | output | DATA_W | Right-justified load result |
| out_fault | output | 1 | Load was rejected |

## Verification
The bound checker covers several timing rules on every cycle. It checks that reads happen only while busy, that read strobes last a single cycle, and that a result never appears while busy is high. It also checks the fault responses: a rejected load faults in the next cycle with zero data and starts no read.

Only the bench scenarios can show the actual byte selection. These cover which bytes get stitched from two words, little-endian placement and sign extension, and the order of the two read addresses, including wrap-around at the top. They also show that a request arriving while busy leaves no trace.

// File: rtl/ld_stitch_pkg.sv
package ld_stitch_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_WAIT_HI = 2'd2
  } seq_state_e;

  // byte count of a size code; reserved code yields 8 and is rejected upstream
  function automatic int unsigned size_to_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/ld_stitch_decode.sv
module ld_stitch_decode #(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  input  logic             strict,
  output logic             fault,
  output logic             split
);
  import ld_stitch_pkg::*;

  logic [CNT_W-1:0] nbytes;
  logic [CNT_W:0]   end_pos;
  logic             misaligned;
  logic             rsvd;

  always_comb begin
    nbytes     = CNT_W'(size_to_bytes(size));
    rsvd       = (size == SZ_RSVD);
    misaligned = (off & OFF_W'(nbytes - CNT_W'(1))) != '0;
    end_pos    = {1'b0, CNT_W'(off)} + {1'b0, nbytes};
    fault      = rsvd || (strict && misaligned);
    split      = !fault && (end_pos > (CNT_W+1)'(BYTES));
  end
endmodule

// File: rtl/ld_stitch_merge.sv
module ld_stitch_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int IDX_W = OFF_W + 1,
  localparam int CNT_W = OFF_W + 1
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result
);
  import ld_stitch_pkg::*;

  logic [2*DATA_W-1:0] window;
  logic [CNT_W-1:0]    nbytes;
  logic [7:0]          raw  [BYTES];
  logic [BYTES-1:0]    keep;
  logic                top_bit;

  assign window = {hi_word, lo_word};
  assign nbytes = CNT_W'(size_to_bytes(size));

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [IDX_W-1:0] src;
    assign src     = IDX_W'(off) + IDX_W'(i);
    assign raw[i]  = window[src*8 +: 8];
    assign keep[i] = CNT_W'(i) < nbytes;
    assign result[i*8 +: 8] = keep[i] ? raw[i] : {8{sgn & top_bit}};
  end

  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < BYTES; i++) begin
      if (CNT_W'(i + 1) == nbytes) top_bit = raw[i][7];
    end
  end
endmodule

// File: rtl/ld_stitch_seq.sv
module ld_stitch_seq #(
  parameter int AW     = 16,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA    = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              dec_fault,
  input  logic              dec_split,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic [DATA_W-1:0] merged,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [WA-1:0]     mem_rd_addr,
  output logic [DATA_W-1:0] mrg_lo,
  output logic [DATA_W-1:0] mrg_hi,
  output logic [OFF_W-1:0]  hold_off,
  output logic [1:0]        hold_size,
  output logic              hold_sgn,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fault
);
  import ld_stitch_pkg::*;

  seq_state_e        state;
  logic              split_q;
  logic [DATA_W-1:0] lo_q;
  logic              accept;

  assign busy   = (state != ST_IDLE);
  assign accept = req_valid && !busy;
  assign mrg_lo = (state == ST_WAIT_HI) ? lo_q : mem_rd_data;
  assign mrg_hi = mem_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      split_q     <= 1'b0;
      lo_q        <= '0;
      hold_off    <= '0;
      hold_size   <= SZ_BYTE;
      hold_sgn    <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_fault   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_fault) begin
              out_valid <= 1'b1;
              out_fault <= 1'b1;
              out_data  <= '0;
            end else begin
              hold_off    <= req_addr[OFF_W-1:0];
              hold_size   <= req_size;
              hold_sgn    <= req_signed;
              split_q     <= dec_split;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= req_addr[AW-1:OFF_W];
              state       <= ST_WAIT_LO;
            end
          end
        end
        ST_WAIT_LO: begin
          if (mem_rd_valid) begin
            if (split_q) begin
              lo_q        <= mem_rd_data;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= mem_rd_addr + WA'(1);
              state       <= ST_WAIT_HI;
            end else begin
              out_valid <= 1'b1;
              out_fault <= 1'b0;
              out_data  <= merged;
              state     <= ST_IDLE;
            end
          end
        end
        ST_WAIT_HI: begin
          if (mem_rd_valid) begin
            out_valid <= 1'b1;
            out_fault <= 1'b0;
            out_data  <= merged;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ld_word_stitch.sv
module ld_word_stitch #(
  parameter int AW     = 16,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA    = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              strict_align,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [WA-1:0]     mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fault
);
  logic              dec_fault, dec_split;
  logic [DATA_W-1:0] mrg_lo, mrg_hi, merged;
  logic [OFF_W-1:0]  hold_off;
  logic [1:0]        hold_size;
  logic              hold_sgn;

  ld_stitch_decode #(.BYTES(BYTES)) u_decode (
    .off    (req_addr[OFF_W-1:0]),
    .size   (req_size),
    .strict (strict_align),
    .fault  (dec_fault),
    .split  (dec_split)
  );

  ld_stitch_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_word (mrg_lo),
    .hi_word (mrg_hi),
    .off     (hold_off),
    .size    (hold_size),
    .sgn     (hold_sgn),
    .result  (merged)
  );

  ld_stitch_seq #(.AW(AW), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_signed   (req_signed),
    .dec_fault    (dec_fault),
    .dec_split    (dec_split),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .merged       (merged),
    .busy         (busy),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mrg_lo       (mrg_lo),
    .mrg_hi       (mrg_hi),
    .hold_off     (hold_off),
    .hold_size    (hold_size),
    .hold_sgn     (hold_sgn),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_fault    (out_fault)
  );
endmodule

// File: rtl/ld_word_stitch_chk.sv
module ld_word_stitch_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_off,
  input logic [1:0]        req_size,
  input logic              strict_align,
  input logic              busy,
  input logic              mem_rd_en,
  input logic              out_valid,
  input logic              out_fault,
  input logic [DATA_W-1:0] out_data
);
  logic taken, bad_align;
  assign taken     = req_valid && !busy;
  assign bad_align = (req_size == 2'b01 && req_off[0]) ||
                     (req_size == 2'b10 && req_off != 2'b00);

  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);                                              // R7
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);                                        // R3
  AST_NO_RESULT_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);                                             // R6
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_data == '0));                   // R8
  AST_STRICT_FAULT: assert property (@(posedge clk) disable iff (rst)
    (taken && strict_align && bad_align) |=> (out_valid && out_fault && !mem_rd_en && !busy)); // R8
  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (rst)
    (taken && req_size == 2'b11) |=> (out_valid && out_fault && !mem_rd_en)); // R9
  AST_LAX_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (taken && !strict_align && req_size != 2'b11) |=> (mem_rd_en && busy)); // R10
endmodule

bind ld_word_stitch ld_word_stitch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_off      (req_addr[1:0]),
  .req_size     (req_size),
  .strict_align (strict_align),
  .busy         (busy),
  .mem_rd_en    (mem_rd_en),
  .out_valid    (out_valid),
  .out_fault    (out_fault),
  .out_data     (out_data)
);

// File: tb/ld_word_stitch_test.sv
`timescale 1ns/1ps
module ld_word_stitch_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WA = AW - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'b00;
  logic req_signed = 1'b0;
  logic strict_align = 1'b0;
  logic busy, mem_rd_en, out_valid, out_fault;
  logic [WA-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0, cyc = 0, rd_tot = 0, last_val_cyc = -1;
  logic [WA-1:0] prev_addr = '0, last_addr = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  ld_word_stitch #(.AW(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed), .strict_align(strict_align),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_fault(out_fault));

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h9C;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rd_valid <= mem_rd_en;
    if (mem_rd_en) begin
      mem_rd_data <= {mbyte({mem_rd_addr, 2'd3}), mbyte({mem_rd_addr, 2'd2}),
                      mbyte({mem_rd_addr, 2'd1}), mbyte({mem_rd_addr, 2'd0})};
      rd_tot    <= rd_tot + 1;
      prev_addr <= last_addr;
      last_addr <= mem_rd_addr;
    end
  end
  always @(negedge clk) if (mem_rd_valid) last_val_cyc = cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entries: addr[19:4], size[3:2], signed[1], strict[0]
  localparam logic [19:0] VEC [16] = '{
    {16'h0060, 2'b10, 1'b0, 1'b0}, {16'h0063, 2'b10, 1'b0, 1'b0},
    {16'h0061, 2'b01, 1'b0, 1'b0}, {16'h0063, 2'b01, 1'b0, 1'b0},
    {16'h0062, 2'b00, 1'b1, 1'b0}, {16'h0077, 2'b01, 1'b1, 1'b0},
    {16'h0045, 2'b10, 1'b0, 1'b0}, {16'h0046, 2'b10, 1'b0, 1'b0},
    {16'h0080, 2'b00, 1'b1, 1'b1}, {16'h0083, 2'b00, 1'b0, 1'b1},
    {16'h0082, 2'b01, 1'b1, 1'b1}, {16'h0081, 2'b01, 1'b0, 1'b1},
    {16'h0086, 2'b10, 1'b0, 1'b1}, {16'h0088, 2'b11, 1'b0, 1'b0},
    {16'hFFFF, 2'b10, 1'b0, 1'b0}, {16'h0010, 2'b10, 1'b0, 1'b1}
  };

  task automatic run_load(input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic sg, input logic st);
    int n, off, start, reads, acc_cyc, waited;
    bit fault, split;
    logic [31:0] exp;
    logic [WA-1:0] wlo;
    n = (sz == 2'b11) ? 0 : (1 << sz);
    off = int'(a[1:0]);
    fault = (sz == 2'b11) || (st && n > 1 && (off % n) != 0);
    split = !fault && (off + n > 4);
    exp = '0;
    if (!fault) begin
      for (int k = 0; k < n; k++) exp[k*8 +: 8] = mbyte(a + AW'(k));
      if (sg && n < 4 && exp[n*8-1]) for (int k = n*8; k < 32; k++) exp[k] = 1'b1;
    end
    wlo = a[AW-1:2];
    @(negedge clk);
    start = rd_tot;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sg; strict_align = st;
    @(negedge clk);
    req_valid = 1'b0;
    acc_cyc = cyc;
    check(busy == !fault, fault ? "R8" : "R7", "busy after accept", 32'(busy), 32'(!fault));
    waited = 0;
    while (!out_valid && waited < 30) begin @(negedge clk); waited++; end
    check(out_valid, "R6", "result arrives", 32'(out_valid), 32'd1);
    check(out_fault == fault, fault ? (sz == 2'b11 ? "R9" : "R8") : "R10", "fault flag",
          32'(out_fault), 32'(fault));
    check(out_data == exp, sg ? "R5" : "R4", "load data", out_data, exp);
    reads = rd_tot - start;
    check(reads == (fault ? 0 : (split ? 2 : 1)), split ? "R3" : "R2", "read count",
          32'(reads), 32'(fault ? 0 : (split ? 2 : 1)));
    if (fault)
      check(cyc == acc_cyc, "R8", "fault timing", 32'(cyc), 32'(acc_cyc));
    else
      check(cyc == last_val_cyc + 1, "R6", "result timing", 32'(cyc), 32'(last_val_cyc + 1));
    if (split) begin
      check(prev_addr == wlo, "R3", "first read addr", 32'(prev_addr), 32'(wlo));
      check(last_addr == wlo + WA'(1), a == 16'hFFFF ? "R11" : "R3", "second read addr",
            32'(last_addr), 32'(wlo + WA'(1)));
    end else if (!fault) begin
      check(last_addr == wlo, "R2", "read addr", 32'(last_addr), 32'(wlo));
    end
    @(negedge clk);
    check(!out_valid, "R6", "result is one pulse", 32'(out_valid), 32'd0);
  endtask

  initial begin
    int start;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd_en && !out_valid, "R1", "idle in reset",
          {29'd0, busy, mem_rd_en, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_rd_en && !out_valid, "R1", "idle after reset",
          {29'd0, busy, mem_rd_en, out_valid}, 32'd0);

    for (int i = 0; i < 16; i++)
      run_load(VEC[i][19:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);

    // R7: request during busy is ignored
    @(negedge clk);
    start = rd_tot;
    req_valid = 1'b1; req_addr = 16'h0063; req_size = 2'b10; req_signed = 1'b0; strict_align = 1'b0;
    @(negedge clk);
    req_addr = 16'h0010; req_size = 2'b00;
    check(busy, "R7", "busy during split", 32'(busy), 32'd1);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    exp = {mbyte(16'h0066), mbyte(16'h0065), mbyte(16'h0064), mbyte(16'h0063)};
    check(out_data == exp, "R7", "busy request ignored data", out_data, exp);
    repeat (5) begin
      @(negedge clk);
      check(!out_valid && !busy, "R7", "no late result", {30'd0, out_valid, busy}, 32'd0);
    end
    check(rd_tot - start == 2, "R7", "no extra reads", 32'(rd_tot - start), 32'd2);

    // R1: reset mid-load
    req_valid = 1'b1; req_addr = 16'h0045; req_size = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd_en && !out_valid, "R1", "reset aborts load",
          {29'd0, busy, mem_rd_en, out_valid}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!out_valid && !busy, "R1", "quiet after abort", {30'd0, out_valid, busy}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule